// File: doc/BRIEF.md
# Delayed-Slot Next-PC Unit

This block sequences the program counter of a 32-bit RISC core whose control transfers have one architectural delay slot. The core presents the instruction at the current PC together with the values of its two source registers and raises a step strobe when that instruction retires. The unit decodes the control-transfer opcodes, resolves unsigned compares, and records a taken target in a pending-branch register. The instruction in the delay slot still executes, and the step after it loads the recorded target into the PC.

The unit also drives the link-register write port for jump-and-link and software-interrupt instructions. It holds the interrupt-enable bit that the enable, disable and return-from-interrupt instructions change, and it pulses a trap output for system calls. Fetch, the register file and interrupt entry belong to neighbouring blocks. A branch decoded in a delay slot is dropped, so the target recorded first always wins.

Top module: `npcu_top`

## Requirements
- R1: After reset, pcQ is 0, no branch is pending (nextPc is 4), and intEnable is 0.
- R2: With no branch pending, a step moves pcQ to pcQ+4. Without stepValid, pcQ, the pending state and intEnable hold, and linkWe and trapPulse stay 0.
- R3: Opcodes in bits 30:25 (with bit 31 zero) select a conditional branch: 24 takes when srcA < srcB, 25 when srcA <= srcB, 26 when srcA == srcB, and 29 when srcA != srcB. All compares are unsigned.
- R4: Conditional branches, DBNZ (30) and jump (27, always taken) target pcQ plus the sign-extended 16-bit offset in bits 15:0.
- R5: A taken transfer at address P does not change the next step's PC. The step at P moves the PC to P+4, and the step at P+4 moves it to the target.
- R6: Jump-and-link (28) with srcA nonzero raises linkWe with linkIdx = bits 15:12 and linkData = pcQ+8, and targets srcA.
- R7: Jump-and-link with srcA equal to zero is a system call. It raises trapPulse, writes no link, and schedules no branch.
- R8: Decrement-branch (30) is taken exactly when srcA is nonzero.
- R9: Software interrupt (50) raises linkWe with linkIdx = bits 15:12 and linkData = pcQ+4, raises trapPulse, and schedules no branch.
- R10: Opcode 48 sets intEnable, 49 clears it, and return-from-interrupt (51) sets it and targets srcA. The change is visible after the step edge.
- R11: When the instruction is in a delay slot, opcodes 24 to 30 and 51 have no effect: no new branch, link, trap or intEnable change. The PC still goes to the first target. Opcodes 48, 49 and 50 still act in a slot.
- R12: An instruction with bit 31 set is not a control transfer. Its step only advances or resolves the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stepValid | input | 1 | Instruction at pcQ retires this cycle |
| instr | input | 32 | Instruction word at pcQ |
| srcA | input | 32 | Value of source register 1 (bits 23:20) |
| srcB | input | 32 | Value of source register 2 (bits 19:16) |
| pcQ | output | 32 | Current program counter |
| nextPc | output | 32 | PC taken at the next step |
| linkWe | output | 1 | Link-register write strobe |
| linkIdx | output | 4 | Link destination register, bits 15:12 |
| linkData | output | 32 | Return address to write |
| intEnable | output | 1 | Interrupt-enable state |
| trapPulse | output | 1 | System-call trap pulse |

## Verification
A pending flag that is lost, stuck or set by mistake shows on nextPc in the same cycle. It shows on pcQ at the next step edge, as a target applied one instruction early, never applied, or applied twice. Errors in decode or in the compares show at once on linkWe, trapPulse or nextPc one step later. Errors in intEnable show right after the step that caused them. A bench model follows every step over thousands of random instructions, including back-to-back transfers in delay slots. Any divergence in pending state is therefore caught within two steps of its cause.

// File: rtl/npcu_pkg.sv
package npcu_pkg;
  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OP_BRLT = 6'd24;
  localparam logic [OPC_W-1:0] OP_BRLE = 6'd25;
  localparam logic [OPC_W-1:0] OP_BREQ = 6'd26;
  localparam logic [OPC_W-1:0] OP_JMP  = 6'd27;
  localparam logic [OPC_W-1:0] OP_JAL  = 6'd28;
  localparam logic [OPC_W-1:0] OP_BRNE = 6'd29;
  localparam logic [OPC_W-1:0] OP_DBNZ = 6'd30;
  localparam logic [OPC_W-1:0] OP_EI   = 6'd48;
  localparam logic [OPC_W-1:0] OP_DI   = 6'd49;
  localparam logic [OPC_W-1:0] OP_SI   = 6'd50;
  localparam logic [OPC_W-1:0] OP_RETI = 6'd51;

  // strobes from decode to the datapath
  typedef struct packed {
    logic branch;    // schedule a pending target
    logic useReg;    // target is srcA, else pc-relative
    logic linkWe;    // write return address
    logic linkPlus8; // return address pc+8, else pc+4
    logic trap;      // system-call pulse
    logic ieSet;
    logic ieClr;
  } npcStrobes_t;
endpackage

// File: rtl/npcu_ctrl.sv
module npcu_ctrl
  import npcu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            stepValid,
  input  logic            slotBusy,
  input  logic [6:0]      opField,   // instruction bits 31:25
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  output npcStrobes_t     strb
);
  logic [OPC_W-1:0] opc;
  logic isCtl, xferOk, aLtB, aEqB, aZero;

  assign opc    = opField[OPC_W-1:0];
  assign isCtl  = stepValid && !opField[6];
  assign xferOk = isCtl && !slotBusy;
  assign aLtB   = srcA < srcB;
  assign aEqB   = srcA == srcB;
  assign aZero  = srcA == '0;

  always_comb begin
    strb = '0;
    if (isCtl) begin
      case (opc)
        OP_BRLT: strb.branch = xferOk && aLtB;
        OP_BRLE: strb.branch = xferOk && (aLtB || aEqB);
        OP_BREQ: strb.branch = xferOk && aEqB;
        OP_BRNE: strb.branch = xferOk && !aEqB;
        OP_DBNZ: strb.branch = xferOk && !aZero;
        OP_JMP:  strb.branch = xferOk;
        OP_JAL: begin
          if (xferOk && aZero) begin
            strb.trap = 1'b1;
          end else if (xferOk) begin
            strb.branch    = 1'b1;
            strb.useReg    = 1'b1;
            strb.linkWe    = 1'b1;
            strb.linkPlus8 = 1'b1;
          end
        end
        OP_RETI: begin
          strb.branch = xferOk;
          strb.useReg = xferOk;
          strb.ieSet  = xferOk;
        end
        OP_EI: strb.ieSet = 1'b1;
        OP_DI: strb.ieClr = 1'b1;
        OP_SI: begin
          strb.linkWe = 1'b1;
          strb.trap   = 1'b1;
        end
        default: strb = '0;
      endcase
    end
  end
endmodule

// File: rtl/npcu_dpath.sv
module npcu_dpath
  import npcu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            stepValid,
  input  npcStrobes_t     strb,
  input  logic [IMMW-1:0] offset,
  input  logic [XLEN-1:0] srcA,
  output logic [XLEN-1:0] pcQ,
  output logic [XLEN-1:0] nextPc,
  output logic [XLEN-1:0] linkData,
  output logic            pendValid,
  output logic            ieQ
);
  localparam int EXTW = XLEN - IMMW;

  logic [XLEN-1:0] pendTarget, relTarget, brTarget, seqPc;

  assign seqPc     = pcQ + XLEN'(4);
  assign relTarget = pcQ + {{EXTW{offset[IMMW-1]}}, offset};
  assign brTarget  = strb.useReg ? srcA : relTarget;
  assign nextPc    = pendValid ? pendTarget : seqPc;
  assign linkData  = strb.linkPlus8 ? pcQ + XLEN'(8) : seqPc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ        <= '0;
      pendValid  <= 1'b0;
      pendTarget <= '0;
      ieQ        <= 1'b0;
    end else if (stepValid) begin
      pcQ       <= nextPc;
      pendValid <= strb.branch;
      if (strb.branch) pendTarget <= brTarget;
      if (strb.ieSet)      ieQ <= 1'b1;
      else if (strb.ieClr) ieQ <= 1'b0;
    end
  end
endmodule

// File: rtl/npcu_top.sv
module npcu_top
  import npcu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            stepValid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  output logic [XLEN-1:0] pcQ,
  output logic [XLEN-1:0] nextPc,
  output logic            linkWe,
  output logic [3:0]      linkIdx,
  output logic [XLEN-1:0] linkData,
  output logic            intEnable,
  output logic            trapPulse
);
  npcStrobes_t strb;
  logic pendValid;
  logic unusedInstr;

  assign unusedInstr = ^{instr[24:16], instr[11:0]};

  npcu_ctrl #(.XLEN(XLEN)) ctrl_i (
    .stepValid(stepValid),
    .slotBusy (pendValid),
    .opField  (instr[31:25]),
    .srcA     (srcA),
    .srcB     (srcB),
    .strb     (strb)
  );

  npcu_dpath #(.XLEN(XLEN), .IMMW(16)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .stepValid(stepValid),
    .strb     (strb),
    .offset   (instr[15:0]),
    .srcA     (srcA),
    .pcQ      (pcQ),
    .nextPc   (nextPc),
    .linkData (linkData),
    .pendValid(pendValid),
    .ieQ      (intEnable)
  );

  assign linkWe    = strb.linkWe;
  assign linkIdx   = instr[15:12];
  assign trapPulse = strb.trap;
endmodule

// File: rtl/npcu_chk.sv
module npcu_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            stepValid,
  input logic [31:0]     instr,
  input logic [XLEN-1:0] pcQ,
  input logic [XLEN-1:0] nextPc,
  input logic            linkWe,
  input logic            trapPulse,
  input logic            intEnable,
  input logic            pendValid
);
  a_r2_pc_holds: assert property (@(posedge clk) disable iff (!rstN)
    !stepValid |=> $stable(pcQ));

  a_r2_step_loads_next: assert property (@(posedge clk) disable iff (!rstN)
    stepValid |=> pcQ == $past(nextPc));

  a_r2_strobes_need_step: assert property (@(posedge clk) disable iff (!rstN)
    (linkWe || trapPulse) |-> stepValid);

  a_r7_syscall_no_link: assert property (@(posedge clk) disable iff (!rstN)
    (trapPulse && instr[31:25] == 7'd28) |-> !linkWe);

  a_r11_slot_consumed: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && pendValid) |=> !pendValid);

  a_r10_ie_rises_on_step: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intEnable) |-> $past(stepValid));
endmodule

bind npcu_top npcu_chk #(.XLEN(XLEN)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .stepValid(stepValid),
  .instr    (instr),
  .pcQ      (pcQ),
  .nextPc   (nextPc),
  .linkWe   (linkWe),
  .trapPulse(trapPulse),
  .intEnable(intEnable),
  .pendValid(pendValid)
);

// File: tb/npcu_top_tb_top.sv
module npcu_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stepValid = 1'b0;
  logic [31:0] instr = 32'h0;
  logic [31:0] srcA = 32'h0;
  logic [31:0] srcB = 32'h0;
  logic [31:0] pcQ, nextPc, linkData;
  logic [3:0]  linkIdx;
  logic linkWe, intEnable, trapPulse;

  int vecs = 0;
  int fails = 0;
  bit done = 0;

  // bench model state
  logic [31:0] mPc = 0, mTgt = 0;
  logic mPend = 0, mIe = 0;

  always #2 clk = ~clk; // 250 MHz

  npcu_top dut_i (
    .clk(clk), .rstN(rstN), .stepValid(stepValid), .instr(instr),
    .srcA(srcA), .srcB(srcB), .pcQ(pcQ), .nextPc(nextPc),
    .linkWe(linkWe), .linkIdx(linkIdx), .linkData(linkData),
    .intEnable(intEnable), .trapPulse(trapPulse)
  );

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [3:0] dst,
                                     input logic [15:0] imm);
    return {1'b0, op, 1'b1, 4'd1, 4'd2, dst, imm[11:0]} | {16'h0, imm};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic doStep(input logic [31:0] ins, input logic [31:0] a,
                        input logic [31:0] b, input logic stp);
    logic [5:0] op = ins[30:25];
    logic ctl = stp && !ins[31];
    logic slot = mPend;
    logic eTake = 0, eLink = 0, eTrap = 0, eIe = mIe;
    logic [31:0] eTgt = 0, eLd = 0;
    logic [31:0] rel = mPc + {{16{ins[15]}}, ins[15:0]};
    logic [31:0] eNext = mPend ? mTgt : mPc + 32'd4;
    string tag = stp ? (ins[31] ? "R12" : "R5") : "R2";
    if (ctl) begin
      case (op)
        6'd24: begin tag = slot ? "R11" : "R3"; eTake = a < b;  eTgt = rel; end
        6'd25: begin tag = slot ? "R11" : "R3"; eTake = a <= b; eTgt = rel; end
        6'd26: begin tag = slot ? "R11" : "R3"; eTake = a == b; eTgt = rel; end
        6'd29: begin tag = slot ? "R11" : "R3"; eTake = a != b; eTgt = rel; end
        6'd27: begin tag = slot ? "R11" : "R4"; eTake = 1;      eTgt = rel; end
        6'd30: begin tag = slot ? "R11" : "R8"; eTake = a != 0; eTgt = rel; end
        6'd28: begin
          tag = slot ? "R11" : (a == 0 ? "R7" : "R6");
          if (a == 0) eTrap = 1;
          else begin eTake = 1; eTgt = a; eLink = 1; eLd = mPc + 8; end
        end
        6'd51: begin tag = slot ? "R11" : "R10"; eTake = 1; eTgt = a; eIe = 1; end
        6'd48: begin tag = "R10"; eIe = 1; end
        6'd49: begin tag = "R10"; eIe = 0; end
        6'd50: begin tag = "R9"; eLink = 1; eTrap = 1; eLd = mPc + 4; end
        default: ;
      endcase
      if (slot && ((op >= 6'd24 && op <= 6'd30) || op == 6'd51)) begin
        eTake = 0; eLink = 0; eTrap = 0; eIe = mIe;
      end
    end
    instr = ins; srcA = a; srcB = b; stepValid = stp;
    #1;
    chk(tag, nextPc, eNext, "nextPc");
    chk(tag, {31'h0, linkWe}, {31'h0, eLink}, "linkWe");
    chk(tag, {31'h0, trapPulse}, {31'h0, eTrap}, "trapPulse");
    if (eLink) begin
      chk(tag, {28'h0, linkIdx}, {28'h0, ins[15:12]}, "linkIdx");
      chk(tag, linkData, eLd, "linkData");
    end
    @(posedge clk); @(negedge clk);
    if (stp) begin
      mPc = eNext; mPend = eTake; mTgt = eTgt; mIe = eIe;
    end
    chk(tag, pcQ, mPc, "pcQ");
    chk(tag, {31'h0, intEnable}, {31'h0, mIe}, "intEnable");
  endtask

  localparam logic [31:0] NOP = 32'h1200_0000; // opcode 9, not a transfer

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", pcQ, 32'h0, "pcQ");
    chk("R1", nextPc, 32'h4, "nextPc");
    chk("R1", {31'h0, intEnable}, 32'h0, "intEnable");
    // R2 sequential and hold
    doStep(NOP, 0, 0, 1);
    doStep(mk(6'd27, 0, 16'h0100), 0, 0, 0);
    doStep(NOP, 0, 0, 1);
    // R3 unsigned: 1 < 0xFFFFFFFF taken, R5 delay slot then target
    doStep(mk(6'd24, 0, 16'h0040), 32'h1, 32'hFFFF_FFFF, 1);
    doStep(NOP, 0, 0, 1);
    doStep(NOP, 0, 0, 1);
    // R4 negative offset via JMP, R11 second jump in slot ignored
    doStep(mk(6'd27, 0, 16'hFFF0), 0, 0, 1);
    doStep(mk(6'd27, 0, 16'h0800), 0, 0, 1);
    doStep(NOP, 0, 0, 1);
    // R6 link and jump, R7 syscall
    doStep(mk(6'd28, 4'd14, 16'h0), 32'h0000_2000, 0, 1);
    doStep(NOP, 0, 0, 1);
    doStep(mk(6'd28, 4'd14, 16'h0), 32'h0, 0, 1);
    // R8 not taken on zero, taken on nonzero
    doStep(mk(6'd30, 0, 16'h0010), 32'h0, 0, 1);
    doStep(mk(6'd30, 0, 16'h0010), 32'h5, 0, 1);
    doStep(mk(6'd50, 4'd3, 16'h0), 0, 0, 1); // R9 in slot still acts
    // R10
    doStep(mk(6'd48, 0, 16'h0), 0, 0, 1);
    doStep(mk(6'd49, 0, 16'h0), 0, 0, 1);
    doStep(mk(6'd51, 0, 16'h0), 32'h0000_0400, 0, 1);
    doStep(mk(6'd51, 0, 16'h0), 32'h0000_0800, 0, 1); // R11 RETI in slot
    // R12 bit 31 set with jump opcode
    doStep(32'h8000_0000 | mk(6'd27, 0, 16'h0100), 0, 0, 1);
    doStep(NOP, 0, 0, 1);
    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] ops [13] = '{6'd24, 6'd25, 6'd26, 6'd27, 6'd28, 6'd29, 6'd30,
                               6'd48, 6'd49, 6'd50, 6'd51, 6'd9, 6'd0};
      logic [31:0] ins, a, b;
      ins = {1'b0, ops[$urandom % 13], $urandom_range(0, 1) == 1, 24'($urandom)};
      if ($urandom % 16 == 0) ins[31] = 1'b1;
      a = ($urandom % 2) ? 32'($urandom % 4) : $urandom;
      b = ($urandom % 2) ? 32'($urandom % 4) : $urandom;
      doStep(ins, a, b, ($urandom % 8) != 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule